// File: doc/BRIEF.md
# Key-Guarded Configuration Register Front End

This block sits in front of a 4 KiB window of 32-bit configuration words. It takes a single-cycle write or read strobe with a byte address. The address is reduced to a word index by dropping its two low bits. Each word index is sorted into one of four classes: readable and writable, read only, write only, or not mapped. The block stores a one-bit control word, a small array of general configuration words, a lock status word and a fixed identifier word.

Writes to the general words go through only while the bank is unlocked. The bank leaves reset locked. Software opens it by writing a 16-bit unlock key to a dedicated address and closes it again by writing a different 16-bit lock key to another address. Writes to the two key addresses and to the control word are always processed, whatever the lock state. Any access that the rules forbid is dropped or answered with zero, and it raises a one-cycle error pulse that a bus wrapper can turn into a slave error.

Top module: `cfglk_bank`

## Requirements
- R1: After reset, `locked` is 1, `access_err` is 0, and the control word and every general word read as zero.
- R2: A write to byte offset 0x008 whose data bits [15:0] equal 0xDF0D clears the lock state on the next clock edge. Data bits [31:16] are ignored.
- R3: A write to byte offset 0x004 whose data bits [15:0] equal 0x767B sets the lock state on the next clock edge.
- R4: A key write whose low 16 bits do not match the key for that address leaves the lock state unchanged and raises no error. This includes a valid key sent to the other key address.
- R5: While locked, a write to a general word (byte offsets 0x100 to 0x13C) is discarded and pulses `access_err`.
- R6: While unlocked, a write to a general word stores all 32 bits, raises no error, and reads back unchanged.
- R7: The control word at byte offset 0x000 accepts writes in either lock state, keeps only data bit 0, and reads back as that bit with zeros above it.
- R8: A write to a read-only word (lock status at 0x00C, identifier at 0x010) or to an unmapped offset is dropped and pulses `access_err`, in either lock state.
- R9: A read from a write-only key address (0x004, 0x008) or from an unmapped offset returns zero and pulses `access_err`.
- R10: A read of byte offset 0x00C returns the lock state in bit 0 and zeros in bits [31:1]. A read of 0x010 returns the BANK_ID parameter. Neither read raises an error.
- R11: Address bits [1:0] are ignored, so any byte address inside a word selects that word.
- R12: `rd_data` and `access_err` are registered on the clock edge that follows the strobe. `access_err` is high for exactly that one cycle unless the next strobe is also illegal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | ADDR_W (12) | Byte address inside the window |
| wr_data | input | DATA_W (32) | Write data |
| rd_data | output | DATA_W (32) | Read data, valid the cycle after `rd_en` |
| locked | output | 1 | Current lock state, 1 when writes to general words are blocked |
| access_err | output | 1 | One-cycle pulse for a dropped or illegal access |

## Verification
The key logic is driven with the correct key and with near-miss values that differ in one bit. It is also driven with correct keys that carry junk in the upper half-word and with correct keys sent to the wrong key address. Together these separate a full 16-bit compare from a partial or 32-bit compare, and an address-qualified key from an unqualified one. General-word writes are issued in both lock states and at both ends of the array, including addresses with nonzero low bits, so that lock gating, index decoding and word alignment fail differently. Reads and writes to every access class, including unmapped offsets, show whether the classifier, rather than the lock, decides that an access is dropped or flagged.

// File: rtl/cfglk_pkg.sv
package cfglk_pkg;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_RO   = 2'd1,
    ACC_WO   = 2'd2,
    ACC_RW   = 2'd3
  } acc_class_e;

  // fixed word indices of the special words
  localparam int unsigned CTRL_WORD   = 0;
  localparam int unsigned LOCK_WORD   = 1;
  localparam int unsigned UNLOCK_WORD = 2;
  localparam int unsigned STAT_WORD   = 3;
  localparam int unsigned ID_WORD     = 4;

  typedef struct packed {
    acc_class_e cls;
    logic       is_ctrl;
    logic       is_lock;
    logic       is_unlock;
    logic       is_stat;
    logic       is_id;
    logic       is_demo;
  } dec_t;

endpackage

// File: rtl/cfglk_rst_sync.sv
module cfglk_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/cfglk_decode.sv
module cfglk_decode
  import cfglk_pkg::*;
#(
  parameter int unsigned WORD_W     = 10,
  parameter int unsigned DEMO_BASE  = 64,
  parameter int unsigned DEMO_WORDS = 16,
  localparam int unsigned IDX_W     = $clog2(DEMO_WORDS)
) (
  input  logic [WORD_W-1:0] word,
  output dec_t              dec,
  output logic [IDX_W-1:0]  demo_idx
);

  logic [WORD_W-1:0] demo_off;

  always_comb begin
    dec           = '0;
    dec.cls       = ACC_NONE;
    dec.is_ctrl   = (word == WORD_W'(CTRL_WORD));
    dec.is_lock   = (word == WORD_W'(LOCK_WORD));
    dec.is_unlock = (word == WORD_W'(UNLOCK_WORD));
    dec.is_stat   = (word == WORD_W'(STAT_WORD));
    dec.is_id     = (word == WORD_W'(ID_WORD));
    dec.is_demo   = (word >= WORD_W'(DEMO_BASE)) &&
                    (word <  WORD_W'(DEMO_BASE + DEMO_WORDS));
    if (dec.is_ctrl || dec.is_demo) begin
      dec.cls = ACC_RW;
    end else if (dec.is_lock || dec.is_unlock) begin
      dec.cls = ACC_WO;
    end else if (dec.is_stat || dec.is_id) begin
      dec.cls = ACC_RO;
    end
  end

  assign demo_off = word - WORD_W'(DEMO_BASE);
  assign demo_idx = demo_off[IDX_W-1:0];

endmodule

// File: rtl/cfglk_keyctl.sv
module cfglk_keyctl #(
  parameter int unsigned         KEY_W      = 16,
  parameter logic [KEY_W-1:0]    LOCK_KEY   = 16'h767B,
  parameter logic [KEY_W-1:0]    UNLOCK_KEY = 16'hDF0D
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_lock,
  input  logic             wr_unlock,
  input  logic [KEY_W-1:0] key,
  output logic             locked
);

  logic lock_q;
  logic lock_d;
  logic lock_en;

  always_comb begin
    lock_en = 1'b0;
    lock_d  = lock_q;
    if (wr_lock && (key == LOCK_KEY)) begin
      lock_en = 1'b1;
      lock_d  = 1'b1;
    end else if (wr_unlock && (key == UNLOCK_KEY)) begin
      lock_en = 1'b1;
      lock_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b1;
    end else if (lock_en) begin
      lock_q <= lock_d;
    end
  end

  assign locked = lock_q;

endmodule

// File: rtl/cfglk_regfile.sv
module cfglk_regfile #(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned DEMO_WORDS = 16,
  localparam int unsigned IDX_W     = $clog2(DEMO_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic              demo_we,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              ctrl_bit,
  output logic [DATA_W-1:0] demo_rd
);

  logic              ctrl_q;
  logic [DATA_W-1:0] demo_q [DEMO_WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= 1'b0;
    end else if (ctrl_we) begin
      ctrl_q <= wr_data[0];
    end
  end

  for (genvar g = 0; g < DEMO_WORDS; g++) begin : g_word
    logic word_en;
    assign word_en = demo_we && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        demo_q[g] <= '0;
      end else if (word_en) begin
        demo_q[g] <= wr_data;
      end
    end
  end

  assign ctrl_bit = ctrl_q;
  assign demo_rd  = demo_q[rd_idx];

endmodule

// File: rtl/cfglk_bank.sv
module cfglk_bank
  import cfglk_pkg::*;
#(
  parameter int unsigned          ADDR_W     = 12,
  parameter int unsigned          DATA_W     = 32,
  parameter int unsigned          KEY_W      = 16,
  parameter logic [KEY_W-1:0]     LOCK_KEY   = 16'h767B,
  parameter logic [KEY_W-1:0]     UNLOCK_KEY = 16'hDF0D,
  parameter int unsigned          DEMO_BASE  = 64,
  parameter int unsigned          DEMO_WORDS = 16,
  parameter logic [DATA_W-1:0]    BANK_ID    = 32'h5A1C_0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              locked,
  output logic              access_err
);

  localparam int unsigned WORD_W = ADDR_W - 2;
  localparam int unsigned IDX_W  = $clog2(DEMO_WORDS);

  logic              rst_sync_n;
  logic [WORD_W-1:0] word;
  logic [1:0]        unused_byte_lane;
  dec_t              dec;
  logic [IDX_W-1:0]  demo_idx;
  logic              lock_state;

  logic              wr_class_ok;
  logic              wr_bypass;
  logic              wr_commit;
  logic              wr_err;
  logic              rd_err;
  logic              ctrl_bit;
  logic [DATA_W-1:0] demo_rd;

  logic [DATA_W-1:0] rd_d;
  logic [DATA_W-1:0] rd_q;
  logic              err_d;
  logic              err_q;

  assign word             = addr[ADDR_W-1:2];
  assign unused_byte_lane = addr[1:0];

  cfglk_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cfglk_decode #(
    .WORD_W     (WORD_W),
    .DEMO_BASE  (DEMO_BASE),
    .DEMO_WORDS (DEMO_WORDS)
  ) u_dec (
    .word     (word),
    .dec      (dec),
    .demo_idx (demo_idx)
  );

  cfglk_keyctl #(
    .KEY_W      (KEY_W),
    .LOCK_KEY   (LOCK_KEY),
    .UNLOCK_KEY (UNLOCK_KEY)
  ) u_key (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_lock   (wr_en && dec.is_lock),
    .wr_unlock (wr_en && dec.is_unlock),
    .key       (wr_data[KEY_W-1:0]),
    .locked    (lock_state)
  );

  // write gating: classifier first, then lock unless the word bypasses it
  always_comb begin
    wr_class_ok = (dec.cls == ACC_RW) || (dec.cls == ACC_WO);
    wr_bypass   = dec.is_ctrl || dec.is_lock || dec.is_unlock;
    wr_commit   = wr_en && wr_class_ok && (wr_bypass || !lock_state);
    wr_err      = wr_en && (!wr_class_ok || (lock_state && !wr_bypass));
    rd_err      = rd_en && ((dec.cls == ACC_WO) || (dec.cls == ACC_NONE));
  end

  cfglk_regfile #(
    .DATA_W     (DATA_W),
    .DEMO_WORDS (DEMO_WORDS)
  ) u_rf (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .ctrl_we  (wr_commit && dec.is_ctrl),
    .demo_we  (wr_commit && dec.is_demo),
    .wr_idx   (demo_idx),
    .wr_data  (wr_data),
    .rd_idx   (demo_idx),
    .ctrl_bit (ctrl_bit),
    .demo_rd  (demo_rd)
  );

  always_comb begin
    rd_d  = rd_q;
    err_d = wr_err || rd_err;
    if (rd_en) begin
      rd_d = '0;
      if (dec.is_ctrl) begin
        rd_d[0] = ctrl_bit;
      end else if (dec.is_stat) begin
        rd_d[0] = lock_state;
      end else if (dec.is_id) begin
        rd_d = BANK_ID;
      end else if (dec.is_demo) begin
        rd_d = demo_rd;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rd_q  <= '0;
      err_q <= 1'b0;
    end else begin
      rd_q  <= rd_d;
      err_q <= err_d;
    end
  end

  assign rd_data    = rd_q;
  assign locked     = lock_state;
  assign access_err = err_q;

endmodule

// File: rtl/cfglk_bank_chk.sv
module cfglk_bank_chk #(
  parameter int unsigned       WORD_W     = 10,
  parameter int unsigned       DATA_W     = 32,
  parameter int unsigned       KEY_W      = 16,
  parameter logic [KEY_W-1:0]  LOCK_KEY   = 16'h767B,
  parameter logic [KEY_W-1:0]  UNLOCK_KEY = 16'hDF0D,
  parameter int unsigned       DEMO_BASE  = 64,
  parameter int unsigned       DEMO_WORDS = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [WORD_W-1:0] word,
  input logic [KEY_W-1:0]  key,
  input logic [DATA_W-1:0] rd_data,
  input logic              locked,
  input logic              access_err
);

  logic demo_hit;
  logic key_addr;
  assign demo_hit = (word >= WORD_W'(DEMO_BASE)) && (word < WORD_W'(DEMO_BASE + DEMO_WORDS));
  assign key_addr = (word == WORD_W'(1)) || (word == WORD_W'(2));

  AST_UNLOCK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && word == WORD_W'(2) && key == UNLOCK_KEY) |=> !locked); // R2

  AST_LOCK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && word == WORD_W'(1) && key == LOCK_KEY) |=> locked); // R3

  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && key_addr) |=> $stable(locked)); // R4

  AST_LOCKED_WRITE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && locked && demo_hit) |=> access_err); // R5

  AST_STATUS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && word == WORD_W'(3)) |=> (rd_data == {{(DATA_W-1){1'b0}}, $past(locked)})); // R10

  AST_ERR_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    access_err |-> $past(wr_en || rd_en)); // R12

endmodule

bind cfglk_bank cfglk_bank_chk #(
  .WORD_W     (ADDR_W - 2),
  .DATA_W     (DATA_W),
  .KEY_W      (KEY_W),
  .LOCK_KEY   (LOCK_KEY),
  .UNLOCK_KEY (UNLOCK_KEY),
  .DEMO_BASE  (DEMO_BASE),
  .DEMO_WORDS (DEMO_WORDS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .wr_en      (wr_en),
  .rd_en      (rd_en),
  .word       (addr[ADDR_W-1:2]),
  .key        (wr_data[KEY_W-1:0]),
  .rd_data    (rd_data),
  .locked     (locked),
  .access_err (access_err)
);

// File: tb/tb_cfglk_bank.sv
module tb_cfglk_bank;

  localparam logic [31:0] ID_VAL = 32'h5A1C_0001;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic        rd_en;
  logic [11:0] addr;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        locked;
  logic        access_err;

  int checks;
  int failures;

  cfglk_bank dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .addr       (addr),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .locked     (locked),
    .access_err (access_err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one write strobe; returns the error pulse seen after the next edge
  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d, output logic err);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    err = access_err;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d, output logic err);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
    err = access_err;
  endtask

  task automatic t_reset();
    logic [31:0] d; logic e;
    check("R1 locked after reset", {31'b0, locked}, 32'd1);
    check("R1 no error after reset", {31'b0, access_err}, 32'd0);
    bus_rd(12'h000, d, e);
    check("R1 control zero", d, 32'd0);
    bus_rd(12'h120, d, e);
    check("R1 general word zero", d, 32'd0);
    bus_rd(12'h00C, d, e);
    check("R10 status reads locked", d, 32'd1);
    check("R10 status read no error", {31'b0, e}, 32'd0);
    bus_rd(12'h010, d, e);
    check("R10 id read", d, ID_VAL);
  endtask

  task automatic t_locked_write();
    logic [31:0] d; logic e;
    bus_wr(12'h104, 32'hAAAA_5555, e);
    check("R5 locked write flagged", {31'b0, e}, 32'd1);
    @(negedge clk);
    check("R12 error pulse one cycle", {31'b0, access_err}, 32'd0);
    bus_rd(12'h104, d, e);
    check("R5 locked write discarded", d, 32'd0);
  endtask

  task automatic t_wrong_key();
    logic e;
    bus_wr(12'h008, 32'h0000_DF0C, e);
    check("R4 near-miss unlock no error", {31'b0, e}, 32'd0);
    check("R4 near-miss unlock keeps lock", {31'b0, locked}, 32'd1);
    bus_wr(12'h004, 32'h0000_DF0D, e);
    check("R4 unlock key at lock address ignored", {31'b0, locked}, 32'd1);
  endtask

  task automatic t_unlock();
    logic [31:0] d; logic e;
    @(negedge clk);
    wr_en = 1'b1; addr = 12'h008; wr_data = 32'hFFFF_DF0D;
    check("R12 lock not yet changed before edge", {31'b0, locked}, 32'd1);
    @(negedge clk);
    wr_en = 1'b0;
    check("R2 unlock with junk upper half", {31'b0, locked}, 32'd0);
    check("R2 unlock no error", {31'b0, access_err}, 32'd0);
    bus_rd(12'h00C, d, e);
    check("R10 status reads unlocked", d, 32'd0);
  endtask

  task automatic t_general_rw();
    logic [31:0] d; logic e;
    bus_wr(12'h100, 32'hCAFE_F00D, e);
    check("R6 write first word no error", {31'b0, e}, 32'd0);
    bus_wr(12'h13C, 32'h1234_5678, e);
    bus_wr(12'h107, 32'h0BAD_BEEF, e);
    bus_rd(12'h100, d, e);
    check("R6 first word readback", d, 32'hCAFE_F00D);
    check("R6 read no error", {31'b0, e}, 32'd0);
    bus_rd(12'h13C, d, e);
    check("R6 last word readback", d, 32'h1234_5678);
    bus_rd(12'h106, d, e);
    check("R11 low address bits ignored", d, 32'h0BAD_BEEF);
    bus_rd(12'h108, d, e);
    check("R6 neighbour untouched", d, 32'd0);
  endtask

  task automatic t_ctrl_unlocked();
    logic [31:0] d; logic e;
    bus_wr(12'h000, 32'hFFFF_FFFE, e);
    bus_rd(12'h000, d, e);
    check("R7 control keeps bit0 only", d, 32'd0);
  endtask

  task automatic t_wrong_lock_key();
    logic e;
    bus_wr(12'h004, 32'h0000_767A, e);
    check("R4 near-miss lock key keeps unlocked", {31'b0, locked}, 32'd0);
    check("R4 near-miss lock key no error", {31'b0, e}, 32'd0);
  endtask

  task automatic t_relock();
    logic [31:0] d; logic e;
    bus_wr(12'h004, 32'hABCD_767B, e);
    check("R3 lock key sets lock", {31'b0, locked}, 32'd1);
    check("R3 lock write no error", {31'b0, e}, 32'd0);
    bus_wr(12'h100, 32'h1111_1111, e);
    check("R5 relocked write flagged", {31'b0, e}, 32'd1);
    bus_rd(12'h100, d, e);
    check("R5 relocked write discarded", d, 32'hCAFE_F00D);
  endtask

  task automatic t_ctrl_locked();
    logic [31:0] d; logic e;
    bus_wr(12'h002, 32'h0000_0003, e);
    check("R7 control write while locked no error", {31'b0, e}, 32'd0);
    bus_rd(12'h000, d, e);
    check("R7 control written while locked", d, 32'd1);
  endtask

  task automatic t_ro_unmapped();
    logic [31:0] d; logic e;
    bus_wr(12'h00C, 32'h0000_0000, e);
    check("R8 status write flagged", {31'b0, e}, 32'd1);
    check("R8 status write dropped", {31'b0, locked}, 32'd1);
    bus_wr(12'h010, 32'hFFFF_FFFF, e);
    check("R8 id write flagged", {31'b0, e}, 32'd1);
    bus_rd(12'h010, d, e);
    check("R8 id unchanged", d, ID_VAL);
    bus_wr(12'h200, 32'h5555_5555, e);
    check("R8 unmapped write flagged", {31'b0, e}, 32'd1);
  endtask

  task automatic t_bad_reads();
    logic [31:0] d; logic e;
    bus_rd(12'h004, d, e);
    check("R9 lock address read zero", d, 32'd0);
    check("R9 lock address read flagged", {31'b0, e}, 32'd1);
    bus_rd(12'h008, d, e);
    check("R9 unlock address read flagged", {31'b0, e}, 32'd1);
    bus_rd(12'h200, d, e);
    check("R9 unmapped read zero", d, 32'd0);
    check("R9 unmapped read flagged", {31'b0, e}, 32'd1);
    @(negedge clk);
    check("R12 error clears after idle", {31'b0, access_err}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks = 0; failures = 0;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_locked_write();
    t_wrong_key();
    t_unlock();
    t_general_rw();
    t_ctrl_unlocked();
    t_wrong_lock_key();
    t_relock();
    t_ctrl_locked();
    t_ro_unmapped();
    t_bad_reads();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule